// File: doc/BRIEF.md
# Single-Fire Lockout Pulse Generator

A clocked monostable that can fire exactly once per reset. When an edge of the chosen polarity arrives on the asynchronous trigger input, the block drives a pulse. The pulse length is a programmable number of milliseconds, converted to clock cycles. The block then latches itself into a spent state. In that state every further trigger activity is ignored until the next reset. Reset stands in for a power cycle. A trigger that is held at its active level, or that chatters during or after the pulse, cannot produce a second pulse.

The trigger passes through a two-flop synchronizer before edge detection. A trigger that already sits at its active level when reset is released is not taken as an edge. The duration input is clamped to the 500 ms to 3000 ms window and captured when the pulse starts. A status output shows whether the block has been used up.

Top module: `single_fire_oneshot`

## Requirements
- R1: The pulse output rises on the third rising clock edge after the trigger changes to its active level. The trigger change is applied between clock edges.
- R2: The pulse lasts exactly clampedMs * CLK_KHZ clock cycles and then falls, even while the trigger is still at its active level.
- R3: A duration value below 500 is treated as 500, and a value above 3000 is treated as 3000.
- R4: Once a pulse has been produced, no further pulse appears until reset. This holds for held triggers and for repeated trigger transitions alike.
- R5: A trigger edge that arrives while the pulse is high neither restarts nor extends the pulse.
- R6: While reset is high, and in the first cycle after it, pulseOut and lockedOut are 0. The block is then armed.
- R7: With fallEdge=0, a low-to-high trigger transition fires the pulse. With fallEdge=1, a high-to-low transition fires it.
- R8: A trigger already at its active level when reset is released does not fire. The first genuine transition to the active level does fire.
- R9: lockedOut rises on the same clock edge as pulseOut and stays 1 until reset.
- R10: The duration value is captured when the pulse starts. Changing durMs during the pulse does not alter that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up model) |
| trigIn | input | 1 | Asynchronous trigger |
| fallEdge | input | 1 | 0: rising transition fires; 1: falling transition fires |
| durMs | input | MS_W | Requested pulse duration in milliseconds |
| pulseOut | output | 1 | The single output pulse |
| lockedOut | output | 1 | 1 once the block has fired, until reset |

## Verification
The block is driven with clean single transitions of both polarities. These separate a correct polarity decode from an inverted one and pin down the three-edge latency. Pulses are driven at durations inside the window, below it and above it, including randomly drawn values. Their measured widths tell the clamp apart from a straight pass-through, and they also show whether the duration is latched or read live. Some pulses are disturbed mid-flight by a new active edge and a changed duration. After each pulse, the trigger is held and toggled repeatedly. A trigger held active across reset release shows whether a stale level is mistaken for an edge.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_PULSE = 2'd1,
    ST_SPENT = 2'd2
  } shotState_t;

  typedef struct packed {
    logic loadTimer;
    logic countEn;
  } timerCtl_t;

endpackage

// File: rtl/oneshot_edge_sync.sv
module oneshot_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trigIn,
  input  logic fallEdge,
  output logic edgeSeen
);
  logic [STAGES-1:0] chain;
  logic              lastLvl;
  logic [STAGES:0]   warm;
  logic              syncLvl;
  logic              activeLvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain   <= '0;
      lastLvl <= 1'b0;
      warm    <= '0;
    end else begin
      chain[0] <= trigIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      lastLvl <= chain[STAGES-1];
      warm    <= {warm[STAGES-1:0], 1'b1};
    end
  end

  assign syncLvl   = chain[STAGES-1];
  assign activeLvl = ~fallEdge;
  // history is trusted only once every stage holds a real sample
  assign edgeSeen  = warm[STAGES] && (syncLvl != lastLvl) && (syncLvl == activeLvl);
endmodule

// File: rtl/oneshot_datapath.sv
module oneshot_datapath #(
  parameter int CLK_KHZ = 1000,
  parameter int MS_W    = 12,
  parameter int MIN_MS  = 500,
  parameter int MAX_MS  = 3000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  oneshot_pkg::timerCtl_t ctl,
  input  logic [MS_W-1:0]       durMs,
  output logic                  timerDone
);
  localparam int MAX_CYC = MAX_MS * CLK_KHZ;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [MS_W-1:0]  msClamped;
  logic [CNT_W-1:0] cycTarget;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (durMs < MS_W'(MIN_MS))      msClamped = MS_W'(MIN_MS);
    else if (durMs > MS_W'(MAX_MS)) msClamped = MS_W'(MAX_MS);
    else                            msClamped = durMs;
  end

  assign cycTarget = CNT_W'(msClamped) * CNT_W'(CLK_KHZ);

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (ctl.loadTimer)          cnt <= cycTarget - CNT_W'(1);
    else if (ctl.countEn && cnt != '0) cnt <= cnt - CNT_W'(1);
  end

  assign timerDone = (cnt == '0);
endmodule

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   edgeSeen,
  input  logic                   timerDone,
  output oneshot_pkg::timerCtl_t ctl,
  output logic                   pulseOut,
  output logic                   lockedOut
);
  import oneshot_pkg::*;

  shotState_t state;
  logic       lockFlag;
  logic       fire;

  // trigger qualified by the inverted lockout flag
  assign fire = edgeSeen && !lockFlag && (state == ST_ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_ARMED;
      lockFlag <= 1'b0;
      pulseOut <= 1'b0;
    end else begin
      case (state)
        ST_ARMED: if (fire) begin
          state    <= ST_PULSE;
          lockFlag <= 1'b1;
          pulseOut <= 1'b1;
        end
        ST_PULSE: if (timerDone) begin
          state    <= ST_SPENT;
          pulseOut <= 1'b0;
        end
        default: begin
          state    <= ST_SPENT;
          pulseOut <= 1'b0;
        end
      endcase
    end
  end

  assign ctl.loadTimer = fire;
  assign ctl.countEn   = (state == ST_PULSE);
  assign lockedOut     = lockFlag;
endmodule

// File: rtl/single_fire_oneshot.sv
module single_fire_oneshot #(
  parameter int CLK_KHZ = 1000,
  parameter int MS_W    = 12,
  parameter int STAGES  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trigIn,
  input  logic            fallEdge,
  input  logic [MS_W-1:0] durMs,
  output logic            pulseOut,
  output logic            lockedOut
);
  oneshot_pkg::timerCtl_t ctl;
  logic edgeSeen;
  logic timerDone;

  oneshot_edge_sync #(.STAGES(STAGES)) uSync (
    .clk(clk), .rst(rst), .trigIn(trigIn), .fallEdge(fallEdge), .edgeSeen(edgeSeen)
  );

  oneshot_ctrl uCtrl (
    .clk(clk), .rst(rst), .edgeSeen(edgeSeen), .timerDone(timerDone),
    .ctl(ctl), .pulseOut(pulseOut), .lockedOut(lockedOut)
  );

  oneshot_datapath #(.CLK_KHZ(CLK_KHZ), .MS_W(MS_W)) uData (
    .clk(clk), .rst(rst), .ctl(ctl), .durMs(durMs), .timerDone(timerDone)
  );
endmodule

// File: rtl/single_fire_oneshot_chk.sv
module single_fire_oneshot_chk #(
  parameter int CLK_KHZ = 1000
) (
  input logic clk,
  input logic rst,
  input logic pulseOut,
  input logic lockedOut
);
  localparam int MIN_CYC = 500 * CLK_KHZ;
  localparam int MAX_CYC = 3000 * CLK_KHZ;
  localparam int W       = $clog2(MAX_CYC + 2) + 1;

  logic [W-1:0] highCnt;
  always_ff @(posedge clk) begin
    if (rst || !pulseOut) highCnt <= '0;
    else                  highCnt <= highCnt + W'(1);
  end

  a_r6_reset_clears: assert property (@(posedge clk) rst |=> (!pulseOut && !lockedOut));
  a_r9_lock_sticky:  assert property (@(posedge clk) disable iff (rst) lockedOut |=> lockedOut);
  a_r9_lock_with_pulse: assert property (@(posedge clk) disable iff (rst) $rose(pulseOut) |-> $rose(lockedOut));
  a_r9_pulse_implies_lock: assert property (@(posedge clk) disable iff (rst) pulseOut |-> lockedOut);
  a_r4_no_refire:    assert property (@(posedge clk) disable iff (rst) (lockedOut && !pulseOut) |=> !pulseOut);
  a_r3_width_max:    assert property (@(posedge clk) disable iff (rst) highCnt <= W'(MAX_CYC));
  a_r3_width_min:    assert property (@(posedge clk) disable iff (rst) $fell(pulseOut) |-> highCnt >= W'(MIN_CYC));
endmodule

bind single_fire_oneshot single_fire_oneshot_chk #(.CLK_KHZ(CLK_KHZ)) uChk (
  .clk(clk), .rst(rst), .pulseOut(pulseOut), .lockedOut(lockedOut)
);

// File: tb/single_fire_oneshot_test.sv
module single_fire_oneshot_test;
  localparam int KHZ  = 4;
  localparam int MS_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigIn = 1'b0;
  logic fallEdge = 1'b0;
  logic [MS_W-1:0] durMs = 12'd600;
  logic pulseOut, lockedOut;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  single_fire_oneshot #(.CLK_KHZ(KHZ), .MS_W(MS_W)) uut (
    .clk(clk), .rst(rst), .trigIn(trigIn), .fallEdge(fallEdge),
    .durMs(durMs), .pulseOut(pulseOut), .lockedOut(lockedOut)
  );

  function automatic int expCycles(input int ms);
    int c;
    c = (ms < 500) ? 500 : ((ms > 3000) ? 3000 : ms);
    return c * KHZ;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic lvl);
    @(negedge clk);
    rst = 1'b1; trigIn = lvl;
    repeat (4) @(negedge clk);
    check(pulseOut == 1'b0 && lockedOut == 1'b0, "R6 outputs low in reset", pulseOut, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pulseOut == 1'b0 && lockedOut == 1'b0, "R6 armed after reset", lockedOut, 0);
  endtask

  task automatic shot(input int ms, input bit falling, input bit disturb);
    logic act;
    int width;
    int highs;
    act = ~falling;
    fallEdge = falling;
    doReset(~act);
    durMs = MS_W'(ms);
    repeat (8) @(negedge clk);
    trigIn = act;
    @(negedge clk); @(negedge clk);
    check(pulseOut == 1'b0, "R1 no pulse before third edge", pulseOut, 0);
    @(negedge clk);
    check(pulseOut == 1'b1, "R1/R7 pulse on third edge", pulseOut, 1);
    check(lockedOut == 1'b1, "R9 lock rises with pulse", lockedOut, 1);
    width = 0;
    while (pulseOut && width < 20000) begin
      width++;
      if (disturb && width == 100) trigIn = ~act;
      if (disturb && width == 200) trigIn = act;
      if (disturb && width == 300) durMs = MS_W'(ms) ^ 12'hA5A;
      @(negedge clk);
    end
    check(width == expCycles(ms), "R2/R3/R5/R10 pulse width", width, expCycles(ms));
    check(pulseOut == 1'b0 && trigIn == act, "R2 falls with trigger still active", pulseOut, 0);
    highs = 0;
    for (int k = 0; k < 6; k++) begin
      trigIn = ~trigIn;
      repeat (20) begin
        @(negedge clk);
        if (pulseOut) highs++;
      end
    end
    check(highs == 0, "R4 no refire after pulse", highs, 0);
    check(lockedOut == 1'b1, "R9 lock held until reset", lockedOut, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r;
    int hi;
    r = $urandom(32'h5EED);
    // R6: reset state
    repeat (3) @(negedge clk);
    check(pulseOut == 1'b0 && lockedOut == 1'b0, "R6 initial reset state", pulseOut, 0);
    // R1 R2 R7: in-range rising and falling
    shot(700, 1'b0, 1'b0);
    shot(900, 1'b1, 1'b0);
    // R3: clamps
    shot(100, 1'b0, 1'b0);
    shot(4000, 1'b1, 1'b0);
    shot(500, 1'b0, 1'b0);
    // R5 R10: disturbance during pulse
    shot(1200, 1'b0, 1'b1);
    shot(50, 1'b1, 1'b1);
    // R8: trigger active when reset releases
    fallEdge = 1'b0;
    doReset(1'b1);
    hi = 0;
    repeat (60) begin @(negedge clk); if (pulseOut) hi++; end
    check(hi == 0, "R8 held level at reset release ignored", hi, 0);
    trigIn = 1'b0; repeat (6) @(negedge clk);
    trigIn = 1'b1; repeat (3) @(negedge clk);
    check(pulseOut == 1'b1, "R8 real transition fires", pulseOut, 1);
    while (pulseOut) @(negedge clk);
    fallEdge = 1'b1;
    doReset(1'b0);
    hi = 0;
    repeat (60) begin @(negedge clk); if (pulseOut) hi++; end
    check(hi == 0, "R8 falling mode held low ignored", hi, 0);
    // random durations and polarities
    for (int n = 0; n < 4; n++) begin
      r = $urandom;
      shot(int'(r[11:0]), r[12], r[13]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule